// File: doc/BRIEF.md
# Programmable-Rate Serial Transmitter

This block turns parallel words into an asynchronous serial bit stream on a single line. A 12-bit divisor, written as a low byte and a 4-bit high part, sets a down-counter that runs on the system clock and emits a rate tick each time it reaches zero. A bit lasts 16 ticks, or 8 ticks when the fast-rate input is set. The frame carries 5 to 9 data bits, an optional even or odd parity bit and one or two stop bits.

Software-side logic writes a word into a one-entry holding buffer, which feeds the frame shift register. A buffer-empty flag shows when the next word may be written. A transmit-done flag shows that the line has gone quiet with nothing left to send. Each flag has its own interrupt enable. The ninth data bit comes from a separate control bit that is latched before the low byte is written.

Top module: `serial_tx`

## Requirements
- R1: The rate tick fires once every divisor+1 system clock cycles, where the divisor is {div_hi_i[3:0], div_lo_i[7:0]} as last written.
- R2: Writing the low divisor byte reloads the down-counter at once, so the first tick after that write comes divisor+1 cycles later.
- R3: A bit lasts 16 rate ticks when fast_i=0 and 8 rate ticks when fast_i=1, so a frame written from idle has a start bit of exactly 16*(div+1)-2 or 8*(div+1)-2 cycles after a low-byte write in the cycle before the data write.
- R4: A frame is a low start bit, then the data bits LSB first, then the parity bit if par_en_i=1, then one stop bit (two_stop_i=0) or two stop bits (two_stop_i=1), both high. char_size_i codes 0,1,2,3 give 5,6,7,8 data bits, and any code of 4 or more gives 9.
- R5: With par_odd_i=0 the data bits plus the parity bit hold an even count of ones. With par_odd_i=1 that count is odd.
- R6: Data bits above the configured size have no effect on the line. The ninth bit is the value of the bit8 control register (written by bit8_we_i) at the moment of the data write.
- R7: After reset txd_o=1, dre_o=1 and tc_o=0, and txd_o stays high whenever no frame is in progress.
- R8: A word written while the shifter is idle starts its frame on the next clock, and dre_o is high again from that cycle.
- R9: A word written before the current frame ends starts with no idle gap right after the last stop bit, and tc_o stays low across the join.
- R10: tc_o sets when a frame ends with the buffer empty, and clears on tc_clr_i or tc_ack_i. dre_irq_o = dre_o AND dre_ie_i, and tc_irq_o = tc_o AND tc_ie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_lo_we_i | input | 1 | Write strobe for low divisor byte (also reloads counter) |
| div_lo_i | input | 8 | Low divisor byte |
| div_hi_we_i | input | 1 | Write strobe for high divisor bits |
| div_hi_i | input | 4 | High divisor bits |
| fast_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| char_size_i | input | 3 | Data bit count code (0..3 = 5..8, 4+ = 9) |
| par_en_i | input | 1 | Append parity bit |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| two_stop_i | input | 1 | 1: two stop bits |
| bit8_we_i | input | 1 | Write strobe for ninth-bit register |
| bit8_i | input | 1 | Ninth data bit value |
| data_we_i | input | 1 | Write strobe for holding buffer |
| data_i | input | 8 | Low data bits |
| tc_clr_i | input | 1 | Write-one clear of transmit-done flag |
| tc_ack_i | input | 1 | Interrupt acknowledge, clears transmit-done flag |
| dre_ie_i | input | 1 | Buffer-empty interrupt enable |
| tc_ie_i | input | 1 | Transmit-done interrupt enable |
| txd_o | output | 1 | Serial line, high when idle |
| dre_o | output | 1 | Holding buffer can accept a word |
| tc_o | output | 1 | Transmit-done flag |
| dre_irq_o | output | 1 | Buffer-empty interrupt |
| tc_irq_o | output | 1 | Transmit-done interrupt |

## Verification
The assertions watch on every cycle that the rate tick spacing matches the divisor mirrored from the write ports, including the counter restart on a low-byte write. They also check that the line is high outside a frame and low at frame start, that a buffered word is taken one cycle after it appears in an idle shifter, and that the done flag rises only with the shifter and buffer both empty. Bit order, parity sense, the ignored upper data bits, the start-bit length after a counter restart and the gapless join of two frames are shown only by the bench. It samples the line at mid-bit against frames it builds itself under random sizes, parity modes, stop counts, rates and divisors.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int DIV_W     = 12;
  localparam int MAX_DATA  = 9;
  localparam int FRAME_W   = 1 + MAX_DATA + 1 + 2;
  localparam int LEN_W     = $clog2(FRAME_W + 1);
  localparam int OSR_NORM  = 16;
  localparam int OSR_FAST  = 8;
  localparam int OSR_W     = $clog2(OSR_NORM);

  typedef struct packed {
    logic [2:0] size;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } tx_cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  function automatic int data_bits(logic [2:0] size);
    return (size > 3'd3) ? MAX_DATA : 5 + int'(size);
  endfunction

  // Stop bits and unused tail are left as ones
  function automatic frame_t build_frame(logic [MAX_DATA-1:0] data, tx_cfg_t cfg);
    frame_t f;
    logic   par;
    int     nb;
    nb     = data_bits(cfg.size);
    f.bits = '1;
    f.bits[0] = 1'b0;
    par = cfg.par_odd;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < nb) begin
        f.bits[1+i] = data[i];
        par         = par ^ data[i];
      end
    end
    if (cfg.par_en) f.bits[1+nb] = par;
    f.len = LEN_W'(1 + nb + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1));
    return f;
  endfunction
endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
  parameter int DIV_W = serial_tx_pkg::DIV_W,
  localparam int HI_W = DIV_W - 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_we_i,
  input  logic [7:0]      lo_i,
  input  logic            hi_we_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            tick_o
);
  logic [HI_W-1:0]  hi_q;
  logic [7:0]       lo_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (hi_we_i) hi_q <= hi_i;
      if (lo_we_i) begin
        lo_q  <= lo_i;
        cnt_q <= {hi_q, lo_i};
      end else if (tick_o) begin
        cnt_q <= {hi_q, lo_q};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
  parameter int DATA_W = serial_tx_pkg::MAX_DATA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] buf_q;
  logic              accept;

  // a write lands if the slot is free or drains in the same cycle
  assign accept = wr_i && (!full_q || take_i);
  assign full_o = full_q;
  assign data_o = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        buf_q  <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = MAX_DATA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fast_i,
  input  tx_cfg_t           cfg_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              take_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              txd_o
);
  logic               busy_q;
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   left_q;
  logic [OSR_W-1:0]   sub_q;
  logic [OSR_W-1:0]   sub_last;
  logic               bit_end;
  logic               last_bit;
  frame_t             nf;

  assign sub_last = fast_i ? OSR_W'(OSR_FAST - 1) : OSR_W'(OSR_NORM - 1);
  assign bit_end  = busy_q && tick_i && (sub_q == sub_last);
  assign last_bit = bit_end && (left_q == LEN_W'(1));
  assign take_o   = hold_full_i && (!busy_q || last_bit);
  assign done_o   = last_bit && !hold_full_i;
  assign busy_o   = busy_q;
  assign txd_o    = !busy_q || frame_q[0];

  always_comb nf = build_frame(hold_data_i, cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      sub_q   <= '0;
    end else if (take_o) begin
      busy_q  <= 1'b1;
      frame_q <= nf.bits;
      left_q  <= nf.len;
      sub_q   <= '0;
    end else if (last_bit) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      sub_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (bit_end) begin
        sub_q   <= '0;
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int DIV_HI_W = DIV_W - 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                div_lo_we_i,
  input  logic [7:0]          div_lo_i,
  input  logic                div_hi_we_i,
  input  logic [DIV_HI_W-1:0] div_hi_i,
  input  logic                fast_i,
  input  logic [2:0]          char_size_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                two_stop_i,
  input  logic                bit8_we_i,
  input  logic                bit8_i,
  input  logic                data_we_i,
  input  logic [7:0]          data_i,
  input  logic                tc_clr_i,
  input  logic                tc_ack_i,
  input  logic                dre_ie_i,
  input  logic                tc_ie_i,
  output logic                txd_o,
  output logic                dre_o,
  output logic                tc_o,
  output logic                dre_irq_o,
  output logic                tc_irq_o
);
  logic                baud_tick;
  logic                bit8_q;
  logic                tc_q;
  logic                hold_full;
  logic [MAX_DATA-1:0] hold_data;
  logic                sh_take;
  logic                sh_done;
  logic                sh_busy;
  tx_cfg_t             cfg;

  assign cfg = '{size: char_size_i, par_en: par_en_i, par_odd: par_odd_i,
                 two_stop: two_stop_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit8_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      if (bit8_we_i) bit8_q <= bit8_i;
      if (sh_done)                    tc_q <= 1'b1;
      else if (tc_clr_i || tc_ack_i)  tc_q <= 1'b0;
    end
  end

  serial_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (div_lo_we_i),
    .lo_i    (div_lo_i),
    .hi_we_i (div_hi_we_i),
    .hi_i    (div_hi_i),
    .tick_o  (baud_tick)
  );

  serial_tx_hold #(.DATA_W(MAX_DATA)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (data_we_i),
    .data_i ({bit8_q, data_i}),
    .take_i (sh_take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  serial_tx_shift #(.DATA_W(MAX_DATA)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick),
    .fast_i      (fast_i),
    .cfg_i       (cfg),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (sh_take),
    .done_o      (sh_done),
    .busy_o      (sh_busy),
    .txd_o       (txd_o)
  );

  assign dre_o     = !hold_full;
  assign tc_o      = tc_q;
  assign dre_irq_o = dre_o && dre_ie_i;
  assign tc_irq_o  = tc_q && tc_ie_i;
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk
  import serial_tx_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                div_lo_we_i,
  input logic [7:0]          div_lo_i,
  input logic                div_hi_we_i,
  input logic [DIV_W-9:0]    div_hi_i,
  input logic                data_we_i,
  input logic                txd_o,
  input logic                dre_o,
  input logic                tc_o,
  input logic                tick_i,
  input logic                busy_i
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] gap_q;
  logic             seen_q;

  // divisor mirrored from the write ports, tick spacing counted independently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (div_hi_we_i) div_q[DIV_W-1:8] <= div_hi_i;
      if (div_lo_we_i) div_q[7:0] <= div_lo_i;
      if (div_hi_we_i) begin
        seen_q <= 1'b0;
        gap_q  <= '0;
      end else if (div_lo_we_i || tick_i) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && seen_q && !div_lo_we_i && !div_hi_we_i) |-> (gap_q == div_q)); // R1 R2

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o); // R7

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !txd_o); // R4

  AST_LOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !dre_o && !data_we_i) |=> (busy_i && dre_o)); // R8

  AST_TC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tc_o) && !$past(data_we_i)) |-> (!busy_i && dre_o)); // R10
endmodule

bind serial_tx serial_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .div_lo_we_i (div_lo_we_i),
  .div_lo_i    (div_lo_i),
  .div_hi_we_i (div_hi_we_i),
  .div_hi_i    (div_hi_i),
  .data_we_i   (data_we_i),
  .txd_o       (txd_o),
  .dre_o       (dre_o),
  .tc_o        (tc_o),
  .tick_i      (baud_tick),
  .busy_i      (sh_busy)
);

// File: tb/tb_serial_tx.sv
module tb_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int SEED       = 1234;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_lo_we = 0, div_hi_we = 0;
  logic [7:0] div_lo = 0;
  logic [3:0] div_hi = 0;
  logic       fast = 0, par_en = 0, par_odd = 0, two_stop = 0;
  logic [2:0] csize = 3;
  logic       bit8_we = 0, bit8 = 0, data_we = 0;
  logic [7:0] data = 0;
  logic       tc_clr = 0, tc_ack = 0, dre_ie = 0, tc_ie = 0;
  logic       txd, dre, tc, dre_irq, tc_irq;

  serial_tx dut (
    .clk_i(clk), .rst_ni(rst_n),
    .div_lo_we_i(div_lo_we), .div_lo_i(div_lo),
    .div_hi_we_i(div_hi_we), .div_hi_i(div_hi),
    .fast_i(fast), .char_size_i(csize), .par_en_i(par_en),
    .par_odd_i(par_odd), .two_stop_i(two_stop),
    .bit8_we_i(bit8_we), .bit8_i(bit8),
    .data_we_i(data_we), .data_i(data),
    .tc_clr_i(tc_clr), .tc_ack_i(tc_ack),
    .dre_ie_i(dre_ie), .tc_ie_i(tc_ie),
    .txd_o(txd), .dre_o(dre), .tc_o(tc),
    .dre_irq_o(dre_irq), .tc_irq_o(tc_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit exp_q [0:31];
  int exp_len = 0;
  int cur_div = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_CYCLES) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [2:0] s);
    return (s >= 3'd4) ? 9 : 5 + int'(s);
  endfunction

  // expected frame appended from the stated frame rules (R4 R5 R6)
  task automatic add_frame(input logic [7:0] d, input logic b8);
    logic [8:0] w;
    int ones;
    int nb;
    w = {b8, d};
    nb = nbits(csize);
    ones = 0;
    exp_q[exp_len++] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      exp_q[exp_len++] = w[i];
      ones += int'(w[i]);
    end
    if (par_en) exp_q[exp_len++] = par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    exp_q[exp_len++] = 1'b1;
    if (two_stop) exp_q[exp_len++] = 1'b1;
  endtask

  function automatic int bit_cycles();
    return (fast ? 8 : 16) * (cur_div + 1);
  endfunction

  task automatic set_div(input int d);
    cur_div = d;
    @(negedge clk); div_hi_we = 1; div_hi = 4'(d >> 8);
    @(negedge clk); div_hi_we = 0; div_lo_we = 1; div_lo = 8'(d);
    @(negedge clk); div_lo_we = 0;
  endtask

  task automatic put(input logic [7:0] d, input logic b8);
    @(negedge clk); bit8_we = 1; bit8 = b8;
    @(negedge clk); bit8_we = 0; data_we = 1; data = d;
    @(negedge clk); data_we = 0;
  endtask

  task automatic clear_tc();
    @(negedge clk); tc_clr = 1;
    @(negedge clk); tc_clr = 0;
  endtask

  // sample mid-bit across all expected bits, frames joined without gaps (R3 R4 R9)
  task automatic watch();
    int t;
    t = bit_cycles();
    while (txd !== 1'b0) @(negedge clk);
    repeat (t/2) @(negedge clk);
    for (int k = 0; k < exp_len; k++) begin
      chk(txd == exp_q[k], "R4 R5 R6 line bit", int'(txd), int'(exp_q[k]));
      chk(tc == 1'b0, "R9 done flag low mid-stream", int'(tc), 0);
      repeat (t) @(negedge clk);
    end
    exp_len = 0;
  endtask

  task automatic after_frame();
    chk(tc == 1'b1, "R10 done flag set", int'(tc), 1);
    chk(tc_irq == tc_ie, "R10 done irq", int'(tc_irq), int'(tc_ie));
    chk(dre == 1'b1, "R8 buffer empty", int'(dre), 1);
    chk(dre_irq == dre_ie, "R10 empty irq", int'(dre_irq), int'(dre_ie));
    chk(txd == 1'b1, "R7 idle high", int'(txd), 1);
  endtask

  initial begin
    int cnt;
    logic [7:0] d, d2;
    logic b8, b8b;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R7 reset line", int'(txd), 1);
    chk(dre == 1'b1, "R7 reset empty", int'(dre), 1);
    chk(tc == 1'b0, "R7 reset done", int'(tc), 0);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1'b1 && dre == 1'b1 && tc == 1'b0, "R7 after reset", int'({txd, dre, tc}), 6);

    // directed: 8N1, check take-on-next-clock (R8)
    set_div(1); csize = 3; par_en = 0; two_stop = 0; fast = 0;
    @(negedge clk); bit8_we = 1; bit8 = 0;
    @(negedge clk); bit8_we = 0; data_we = 1; data = 8'hA5;
    @(negedge clk); data_we = 0;
    chk(dre == 1'b0, "R8 buffer full after write", int'(dre), 0);
    @(negedge clk);
    chk(dre == 1'b1, "R8 empty again next clock", int'(dre), 1);
    chk(txd == 1'b0, "R8 start bit next clock", int'(txd), 0);
    while (tc !== 1'b1) @(negedge clk);
    after_frame();

    // directed: counter restart on low byte, start-bit length (R2 R3)
    clear_tc();
    set_div(0); fast = 1; csize = 3;
    @(negedge clk); div_lo_we = 1; div_lo = 8'd20; cur_div = 20;
    @(negedge clk); div_lo_we = 0; data_we = 1; data = 8'h01;
    @(negedge clk); data_we = 0;
    cnt = 0;
    while (1) begin
      if (txd == 1'b0) cnt++;
      else if (cnt > 0) break;
      @(negedge clk);
    end
    chk(cnt == 8 * 21 - 2, "R2 R3 start bit length after reload", cnt, 8 * 21 - 2);
    while (tc !== 1'b1) @(negedge clk);

    // directed: 5 data bits, upper bits ignored, odd parity, two stops (R6)
    clear_tc();
    set_div(2); fast = 0; csize = 0; par_en = 1; par_odd = 1; two_stop = 1;
    add_frame(8'hE5, 1'b1);
    put(8'hE5, 1'b1);
    watch();
    after_frame();

    // directed: 9 bits via code 7, ninth bit set, even parity (R4 R6)
    clear_tc();
    csize = 7; par_odd = 0; two_stop = 0;
    add_frame(8'h3C, 1'b1);
    put(8'h3C, 1'b1);
    watch();
    after_frame();

    // done flag cleared by acknowledge (R10)
    @(negedge clk); tc_ack = 1;
    @(negedge clk); tc_ack = 0;
    chk(tc == 1'b0, "R10 ack clears done", int'(tc), 0);

    // back-to-back frames, no gap (R9)
    set_div(1); fast = 1; csize = 3; par_en = 1; par_odd = 0;
    d = 8'h5A; d2 = 8'hC3;
    add_frame(d, 1'b0);
    add_frame(d2, 1'b0);
    @(negedge clk); bit8_we = 1; bit8 = 0;
    @(negedge clk); bit8_we = 0; data_we = 1; data = d;
    @(negedge clk); data_we = 0;
    @(negedge clk); data_we = 1; data = d2;
    @(negedge clk); data_we = 0;
    chk(dre == 1'b0, "R9 second word waiting", int'(dre), 0);
    begin
      int t;
      t = bit_cycles();
      // first start bit began before this point; align on its known start
      repeat (t/2 - 4) @(negedge clk);
      for (int k = 0; k < exp_len; k++) begin
        chk(txd == exp_q[k], "R9 joined frames bit", int'(txd), int'(exp_q[k]));
        chk(tc == 1'b0, "R9 no done between frames", int'(tc), 0);
        repeat (t) @(negedge clk);
      end
      exp_len = 0;
    end
    after_frame();

    // random frames (R1 R3 R4 R5 R6 R10)
    for (int n = 0; n < 24; n++) begin
      clear_tc();
      chk(tc == 1'b0, "R10 write-one clears done", int'(tc), 0);
      set_div(int'($urandom % 4));
      fast = 1'($urandom); csize = 3'($urandom); par_en = 1'($urandom);
      par_odd = 1'($urandom); two_stop = 1'($urandom);
      dre_ie = 1'($urandom); tc_ie = 1'($urandom);
      d = 8'($urandom); b8 = 1'($urandom);
      add_frame(d, b8);
      put(d, b8);
      watch();
      after_frame();
    end

    // ninth-bit register persists across writes (R6)
    clear_tc();
    csize = 4; par_en = 0; two_stop = 0; fast = 1; set_div(0);
    b8b = 1'b1;
    @(negedge clk); bit8_we = 1; bit8 = b8b;
    @(negedge clk); bit8_we = 0;
    add_frame(8'h00, b8b);
    @(negedge clk); data_we = 1; data = 8'h00;
    @(negedge clk); data_we = 0;
    watch();
    after_frame();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule